// File: doc/BRIEF.md
# Dual-Pointer Auto-Increment Memory Port

This block gives a byte-wide processor bus a small window of eight registers. Through that window the processor reaches a 20-bit video address space. Two address pointers live inside the block, and each has its own stride. A select bit decides which pointer the three configuration registers program and read back. Two data registers are tied to fixed pointers: one always uses pointer 0 and the other always uses pointer 1. Every access through a data register moves its pointer forward, so a stream of bytes can be copied or filled without reloading the address.

The address of each data access is sorted into one of three areas:
- **Video RAM:** the low 128 KiB.
- **Gap:** an unmapped middle range. Writes there do nothing and reads return 0xFF.
- **Bank window:** the top 64 KiB, split into sixteen 4 KiB banks that belong to outside sub-blocks.

The RAM and the banks are reached through plain request/response ports. These ports have a fixed read latency of one cycle. A soft-reset strobe is also driven out, so that the sub-blocks can clear themselves when the processor asks for it.

Top module: `dpm_port`

## Requirements
- R1: After reset, both pointers are at address 0 with stride code 0, the select bit is 0, and reads of registers 0, 1, 2 and 5 return 0x00.
- R2: A write to register 0, 1 or 2 changes only the pointer named by the select bit:
  - register 0 loads address bits 7:0;
  - register 1 loads address bits 15:8;
  - register 2 loads address bits 19:16 from its low nibble and the stride code from its high nibble.
  A read of registers 0 to 2 returns the byte last written to that register for the selected pointer.
- R3: A stride code c gives a stride of 0 when c is 0 and 2^(c-1) otherwise. Code 1 is 1, code 2 is 2, and code 9 is 256.
- R4: Register 3 always accesses memory through pointer 0 and register 4 always through pointer 1, whatever the select bit is. Each access, read or write, adds that pointer's stride modulo 2^20 and leaves the other pointer unchanged.
- R5: A read of any register raises cpu_rvalid in the next cycle. For a data register, cpu_rdata then holds the byte at the address the pointer had before it advanced.
- R6: A write to register 5 with bit 7 clear sets the select bit to bit 0 of the data. A read of register 5 returns the select bit in bit 0, with zeros above it.
- R7: A write to register 5 with bit 7 set clears both pointers, their strides and their stored bytes, and the select bit. It also raises soft_rst_o for exactly the next cycle.
- R8: A data access below 0x20000 raises ram_req in the same cycle. ram_addr carries address bits 16:0, ram_we is high for a write, and ram_wdata carries the byte.
- R9: A data access from 0x20000 up to 0xEFFFF raises no request, and a read returns 0xFF.
- R10: A data access at 0xF0000 or above whose bank number (address bits 15:12) is 0, 1, 2, 3, 7 or 8 raises bank_req. bank_id carries bits 15:12 and bank_off carries bits 11:0. A read returns bank_rdata from the next cycle.
- R11: A data access to any other bank number at 0xF0000 or above raises no request, and a read returns 0xFF.
- R12: Writes to registers 6 and 7 have no effect, and reads of them return 0xFF.
- R13: Each data access raises exactly one request or none. ram_req and bank_req are never high together, and no request is raised when no data register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 3 | Register number in the window |
| cpu_wr | input | 1 | Write strobe; wins over cpu_rd |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| cpu_rdata | output | 8 | Read data |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| ram_req | output | 1 | Video RAM access request |
| ram_we | output | 1 | Video RAM write enable |
| ram_addr | output | 17 | Video RAM byte address |
| ram_wdata | output | 8 | Video RAM write data |
| ram_rdata | input | 8 | Video RAM read data, one cycle after ram_req |
| bank_req | output | 1 | Register bank access request |
| bank_we | output | 1 | Register bank write enable |
| bank_id | output | 4 | Bank number |
| bank_off | output | 12 | Byte offset within the bank |
| bank_wdata | output | 8 | Bank write data |
| bank_rdata | input | 8 | Bank read data, one cycle after bank_req |

## Verification
Results arrive on two different schedules:
- **Same cycle:** ram_req, bank_req and their address, enable and data lines are combinational. They are due in the cycle the access is presented, so the bench samples them one nanosecond after it drives its inputs at the falling edge.
- **Next cycle:** read data, cpu_rvalid and soft_rst_o are due one cycle after the rising edge that takes the access. The bench samples them at the following falling edge. The new pointer value shows up only through the address of the next access or through register readback.

The reference model keeps the pointers, stored bytes, select bit and memory contents as plain integers and arrays. It changes them only after the rising edge, so the expected read value is always taken from the state before the access.

// File: rtl/dpm_pkg.sv
// Shared types and helpers for the dual-pointer memory port.
// Assumes a 20-bit video address space and a 16-bit stride field.
package dpm_pkg;
    localparam int VA_W   = 20;
    localparam int STEP_W = 16;

    typedef enum logic [1:0] {RG_RAM, RG_GAP, RG_BANK} region_t;
    typedef enum logic [1:0] {SRC_REG, SRC_RAM, SRC_BANK, SRC_NONE} rsrc_t;

    // Stride from its 4-bit code: zero for code 0, otherwise a single set bit.
    function automatic logic [STEP_W-1:0] step_of(input logic [3:0] code);
        logic [STEP_W-1:0] s;
        s = '0;
        if (code != 4'd0) s[code - 4'd1] = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/dpm_pointer.sv
// One address pointer with its stride code and three stored config bytes.
// Assumes wr_en and adv are never high together (the top guarantees this).
// clr is the soft-reset request and behaves like rst_n.
module dpm_pointer
    import dpm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 adv,
    output logic [VA_W-1:0]      addr,
    output logic [2:0][7:0]      raw
);
    logic [STEP_W-1:0] step;

    // Stride derived from the stored code nibble.
    assign step = step_of(raw[2][7:4]);

    // Pointer and config-byte state: clear, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
            raw  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                2'd0: begin raw[0] <= wr_data; addr[7:0]  <= wr_data; end
                2'd1: begin raw[1] <= wr_data; addr[15:8] <= wr_data; end
                default: begin
                    raw[2] <= wr_data;
                    addr[VA_W-1:16] <= wr_data[VA_W-17:0];
                end
            endcase
        end else if (adv) begin
            addr <= addr + VA_W'(step);
        end
    end

    a_r3_step_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) <= 1);

    a_r4_nonzero_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !wr_en && step != '0) |=> addr != $past(addr));

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addr == '0 && raw == '0));
endmodule

// File: rtl/dpm_decode.sv
// Sorts a 20-bit address into RAM, gap or bank window.
// Assumes the bank window is the top 64 KiB. BANK_MASK marks which
// 4 KiB banks have a responder behind them.
module dpm_decode
    import dpm_pkg::*;
#(
    parameter int          RAM_AW    = 17,
    parameter logic [15:0] BANK_MASK = 16'h018F
) (
    input  logic [VA_W-1:0] addr,
    output region_t         region,
    output logic            bank_hit,
    output logic [3:0]      bank_id,
    output logic [11:0]     bank_off
);
    // Area select from the upper address bits.
    always_comb begin
        if (addr[VA_W-1:RAM_AW] == '0)       region = RG_RAM;
        else if (addr[VA_W-1:16] == '1)      region = RG_BANK;
        else                                 region = RG_GAP;
    end

    assign bank_id  = addr[15:12];
    assign bank_off = addr[11:0];
    assign bank_hit = (region == RG_BANK) && BANK_MASK[bank_id];
endmodule

// File: rtl/dpm_port.sv
// Eight-register processor window with two auto-advancing pointers.
// Assumes at most one of cpu_wr/cpu_rd per cycle is meaningful (write wins),
// and that RAM and banks answer reads exactly one cycle after the request.
module dpm_port
    import dpm_pkg::*;
#(
    parameter int          RAM_AW    = 17,
    parameter logic [15:0] BANK_MASK = 16'h018F,
    localparam int         NPTR      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_rvalid,
    output logic [7:0]        cpu_rdata,
    output logic              soft_rst_o,
    output logic              ram_req,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              bank_req,
    output logic              bank_we,
    output logic [3:0]        bank_id,
    output logic [11:0]       bank_off,
    output logic [7:0]        bank_wdata,
    input  logic [7:0]        bank_rdata
);
    logic                        sel_q;
    logic                        soft_q;
    logic                        rvalid_q;
    rsrc_t                       src_q;
    logic [7:0]                  hold_q;
    logic [NPTR-1:0][VA_W-1:0]   p_addr;
    logic [NPTR-1:0][2:0][7:0]   p_raw;
    logic                        rd_go, cfg_wr, data_acc, port, soft_hit;
    logic [VA_W-1:0]             acc_addr;
    region_t                     region;
    logic                        bank_hit;
    logic [7:0]                  reg_val;

    // Strobe decode for the current bus cycle.
    assign rd_go    = cpu_rd && !cpu_wr;
    assign cfg_wr   = cpu_wr && (cpu_sel <= 3'd2);
    assign data_acc = (cpu_wr || cpu_rd) && (cpu_sel == 3'd3 || cpu_sel == 3'd4);
    assign port     = (cpu_sel == 3'd4);
    assign soft_hit = cpu_wr && (cpu_sel == 3'd5) && cpu_wdata[7];
    assign acc_addr = p_addr[port];

    // One pointer instance per data register.
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dpm_pointer u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (soft_hit),
            .wr_en   (cfg_wr && (sel_q == 1'(g))),
            .wr_idx  (cpu_sel[1:0]),
            .wr_data (cpu_wdata),
            .adv     (data_acc && (port == 1'(g))),
            .addr    (p_addr[g]),
            .raw     (p_raw[g])
        );
    end

    dpm_decode #(.RAM_AW(RAM_AW), .BANK_MASK(BANK_MASK)) u_dec (
        .addr     (acc_addr),
        .region   (region),
        .bank_hit (bank_hit),
        .bank_id  (bank_id),
        .bank_off (bank_off)
    );

    // Requests toward RAM and banks, issued in the access cycle.
    assign ram_req    = data_acc && (region == RG_RAM);
    assign ram_we     = cpu_wr;
    assign ram_addr   = acc_addr[RAM_AW-1:0];
    assign ram_wdata  = cpu_wdata;
    assign bank_req   = data_acc && bank_hit;
    assign bank_we    = cpu_wr;
    assign bank_wdata = cpu_wdata;

    // Value of a non-data register for the current select.
    always_comb begin
        case (cpu_sel)
            3'd0, 3'd1, 3'd2: reg_val = p_raw[sel_q][cpu_sel[1:0]];
            3'd5:             reg_val = {7'd0, sel_q};
            default:          reg_val = 8'hFF;
        endcase
    end

    // Select bit, soft-reset pulse and read-return bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            soft_q   <= 1'b0;
            rvalid_q <= 1'b0;
            src_q    <= SRC_NONE;
            hold_q   <= 8'hFF;
        end else begin
            soft_q   <= soft_hit;
            rvalid_q <= rd_go;
            if (soft_hit)                          sel_q <= 1'b0;
            else if (cpu_wr && cpu_sel == 3'd5)    sel_q <= cpu_wdata[0];
            if (rd_go) begin
                hold_q <= reg_val;
                if (!data_acc)                src_q <= SRC_REG;
                else if (region == RG_RAM)    src_q <= SRC_RAM;
                else if (bank_hit)            src_q <= SRC_BANK;
                else                          src_q <= SRC_NONE;
            end
        end
    end

    // Read data return mux.
    always_comb begin
        case (src_q)
            SRC_REG:  cpu_rdata = hold_q;
            SRC_RAM:  cpu_rdata = ram_rdata;
            SRC_BANK: cpu_rdata = bank_rdata;
            default:  cpu_rdata = 8'hFF;
        endcase
    end

    assign cpu_rvalid = rvalid_q;
    assign soft_rst_o = soft_q;

    a_r13_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_req, bank_req}));

    a_r5_read_returns_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && region == RG_GAP) |-> (!ram_req && !bank_req));

    a_r7_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (sel_q == 1'b0 && p_addr == '0));
endmodule

// File: tb/dpm_port_test.sv
`timescale 1ns/1ps
module dpm_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  cpu_sel = 0;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_rvalid, soft_rst_o;
    logic [7:0]  cpu_rdata;
    logic        ram_req, ram_we, bank_req, bank_we;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata, bank_wdata;
    logic [7:0]  ram_rdata = 0, bank_rdata = 0;
    logic [3:0]  bank_id;
    logic [11:0] bank_off;

    int n_checks = 0, n_fails = 0;

    // Reference state.
    bit [7:0]  ram_mem  [int];
    bit [7:0]  bank_mem [int];
    int        m_ptr  [2];
    bit [7:0]  m_raw  [2][3];
    int        m_sel;
    localparam bit [15:0] IMPL = 16'h018F;

    always #4 clk = ~clk;

    dpm_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .soft_rst_o(soft_rst_o), .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .bank_req(bank_req), .bank_we(bank_we),
        .bank_id(bank_id), .bank_off(bank_off), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // Memory responders with one-cycle read latency.
    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
            else ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
        end
        if (bank_req) begin
            if (bank_we) bank_mem[int'({bank_id, bank_off})] = bank_wdata;
            else bank_rdata <= bank_mem.exists(int'({bank_id, bank_off}))
                               ? bank_mem[int'({bank_id, bank_off})] : 8'h00;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int stride_m(input int code);
        return (code == 0) ? 0 : (1 << (code - 1));
    endfunction

    // One bus cycle: drive at the falling edge, check requests, then check the return.
    task automatic op(input bit w, input bit r, input logic [2:0] s, input logic [7:0] d,
                      input string tag);
        int a, p;
        bit dacc, e_ram, e_bank;
        logic [7:0] e_val;
        cpu_sel = s; cpu_wr = w; cpu_rd = r; cpu_wdata = d;
        dacc  = (s == 3 || s == 4) && (w || r);
        p     = (s == 4) ? 1 : 0;
        a     = m_ptr[p];
        e_ram = dacc && a < 'h20000;
        e_bank = dacc && (a >> 16) == 'hF && IMPL[(a >> 12) & 'hF];
        #1;
        chk(ram_req === e_ram, {tag, " R13 ram_req"}, int'(ram_req), int'(e_ram));
        chk(bank_req === e_bank, {tag, " R13 bank_req"}, int'(bank_req), int'(e_bank));
        if (e_ram) begin
            chk(ram_addr === a[16:0], {tag, " R8 ram_addr"}, int'(ram_addr), a & 'h1FFFF);
            chk(ram_we === w, {tag, " R8 ram_we"}, int'(ram_we), int'(w));
            if (w) chk(ram_wdata === d, {tag, " R8 ram_wdata"}, int'(ram_wdata), int'(d));
        end
        if (e_bank) begin
            chk({bank_id, bank_off} === a[15:0], {tag, " R10 bank addr"},
                int'({bank_id, bank_off}), a & 'hFFFF);
            chk(bank_we === w, {tag, " R10 bank_we"}, int'(bank_we), int'(w));
        end
        case (s)
            3'd0, 3'd1, 3'd2: e_val = m_raw[m_sel][s];
            3'd5:             e_val = 8'(m_sel);
            3'd3, 3'd4: begin
                if (e_ram)       e_val = ram_mem.exists(a) ? ram_mem[a] : 8'h00;
                else if (e_bank) e_val = bank_mem.exists(a & 'hFFFF) ? bank_mem[a & 'hFFFF] : 8'h00;
                else             e_val = 8'hFF;
            end
            default:          e_val = 8'hFF;
        endcase
        @(posedge clk);
        if (w) begin
            case (s)
                3'd0: begin m_raw[m_sel][0] = d; m_ptr[m_sel] = (m_ptr[m_sel] & 'hFFF00) | d; end
                3'd1: begin m_raw[m_sel][1] = d; m_ptr[m_sel] = (m_ptr[m_sel] & 'hF00FF) | (d << 8); end
                3'd2: begin m_raw[m_sel][2] = d; m_ptr[m_sel] = (m_ptr[m_sel] & 'h0FFFF) | ((d & 'hF) << 16); end
                3'd5: begin
                    if (d[7]) begin
                        m_sel = 0;
                        for (int i = 0; i < 2; i++) begin
                            m_ptr[i] = 0;
                            for (int j = 0; j < 3; j++) m_raw[i][j] = 0;
                        end
                    end else m_sel = d[0];
                end
                default: ;
            endcase
        end
        if (dacc) m_ptr[p] = (m_ptr[p] + stride_m(m_raw[p][2] >> 4)) % (1 << 20);
        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0;
        chk(cpu_rvalid === (r && !w), {tag, " R5 rvalid"}, int'(cpu_rvalid), int'(r && !w));
        if (r && !w) chk(cpu_rdata === e_val, {tag, " rdata"}, int'(cpu_rdata), int'(e_val));
        chk(soft_rst_o === (w && s == 5 && d[7]), {tag, " R7 soft_rst_o"},
            int'(soft_rst_o), int'(w && s == 5 && d[7]));
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
        op(1'b1, 1'b0, s, d, tag);
    endtask
    task automatic rd(input logic [2:0] s, input string tag);
        op(1'b0, 1'b1, s, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        m_sel = 0;
        for (int i = 0; i < 2; i++) begin
            m_ptr[i] = 0;
            for (int j = 0; j < 3; j++) m_raw[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk(cpu_rvalid === 1'b0 && soft_rst_o === 1'b0, "R1 idle outputs", int'(cpu_rvalid), 0);
        rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(5, "R1");
        // Pointer 0 at 0x00010, stride 1; fill three bytes.
        wr(0, 8'h10, "R2"); wr(1, 8'h00, "R2"); wr(2, 8'h10, "R2");
        wr(3, 8'hA1, "R4 R8"); wr(3, 8'hB2, "R4 R8"); wr(3, 8'hC3, "R4 R8");
        rd(0, "R2 raw byte kept"); rd(2, "R2");
        wr(0, 8'h10, "R2");
        rd(3, "R5 R3 stride1"); rd(3, "R5 R3 stride1"); rd(3, "R5 R3 stride1");
        // Pointer 1 at 0x00100, stride 256.
        wr(5, 8'h01, "R6"); rd(5, "R6");
        wr(0, 8'h00, "R2"); wr(1, 8'h01, "R2"); wr(2, 8'h90, "R2");
        wr(4, 8'h11, "R3 stride256"); wr(4, 8'h22, "R3 stride256");
        wr(0, 8'h00, "R2"); wr(1, 8'h01, "R2");
        rd(4, "R3 stride256"); rd(4, "R3 stride256");
        rd(3, "R4 port0 while sel1");
        rd(2, "R2 sel1");
        wr(5, 8'h00, "R6"); rd(2, "R4 independent pointers");
        // Stride 0 and stride 2 on pointer 0.
        wr(2, 8'h00, "R3"); wr(0, 8'h11, "R2");
        rd(3, "R3 stride0"); rd(3, "R3 stride0");
        wr(2, 8'h20, "R3"); wr(0, 8'h10, "R2");
        rd(3, "R3 stride2"); rd(3, "R3 stride2");
        // Wrap from 0xFFFFF to 0x00000.
        wr(0, 8'hFF, "R2"); wr(1, 8'hFF, "R2"); wr(2, 8'h1F, "R2");
        rd(3, "R11 top bank"); rd(3, "R4 wrap");
        // Gap at 0x30000.
        wr(2, 8'h13, "R2"); wr(1, 8'h00, "R2"); wr(0, 8'h00, "R2");
        wr(3, 8'h77, "R9 gap write"); rd(3, "R9 gap read");
        // Bank window.
        wr(2, 8'h0F, "R2"); wr(1, 8'h10, "R2"); wr(0, 8'h05, "R2");
        wr(3, 8'h5A, "R10"); rd(3, "R10 bank1");
        wr(1, 8'h80, "R2"); wr(3, 8'h3C, "R10"); rd(3, "R10 bank8");
        wr(1, 8'h40, "R2"); wr(3, 8'h99, "R11"); rd(3, "R11 bank4");
        // Unused registers.
        wr(6, 8'hAA, "R12"); wr(7, 8'h55, "R12"); rd(6, "R12"); rd(7, "R12");
        rd(1, "R12 config untouched");
        // Soft reset.
        wr(5, 8'h01, "R6");
        wr(5, 8'h81, "R7");
        rd(5, "R7"); rd(0, "R7"); rd(2, "R7");
        wr(5, 8'h01, "R7"); rd(2, "R7 pointer1 cleared");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule